// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block sits between a clocked host and an asynchronous static memory that is 8 bits wide and has 18 address bits. The host issues single-word reads and writes over a valid/ready request channel. The block turns each request into a strobe sequence on the memory pins. Those pins are an active-low select, an active-high select, an active-low write strobe, an active-low output enable, and a shared data bus. The data bus is split into an output, an input and a driver enable. A read returns its byte with a one-cycle valid pulse.

Each analog timing limit of the memory is a nanosecond parameter. The block converts it to a whole number of clock cycles at elaboration, using the clock period parameter. The conversion rounds up and never returns less than one cycle. With the default 20 ns clock, a write takes five cycles: one cycle of setup, three cycles with the write strobe low, and one cycle of data hold. A read takes four cycles with the output enable low. It is then followed by two cycles of bus release before the next request can be taken.

Between accesses, both selects are inactive, so the memory rests in low-power standby.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and right after it is released, the block is idle. In that state req_ready=1, mem_cs_n=1, mem_cs=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and rsp_valid=0.
- R2: req_ready is 1 only while the block is idle. A request is taken on a clock edge where req_valid and req_ready are both 1. mem_addr takes the request address on that edge and holds it until the next request is taken.
- R3: In a write, mem_we_n goes low for ceil(T_PWE/clk) cycles, but longer if the select-to-end or address-to-end limits need it. With defaults this is 3 cycles, giving at least 50 ns. Both selects are active (mem_cs_n=0, mem_cs=1), and the address is steady, at least 60 ns before mem_we_n rises.
- R4: mem_dq_oe is 1 only while mem_oe_n is 1. During a write it is 1 exactly while mem_we_n is low and for the hold cycles that follow. The memory never drives the bus while mem_dq_oe is 1.
- R5: Write data on mem_dq_out is steady at least 30 ns before mem_we_n rises. It is still driven on the edge where mem_we_n rises.
- R6: In a read, both selects are active, mem_oe_n=0 and mem_we_n=1, for N_RD cycles. N_RD is the larger of ceil(70 ns/clk) and ceil(35 ns/clk), which is 4 with defaults. mem_we_n and mem_oe_n are never low together. mem_dq_in is sampled on the edge that ends the read. rsp_valid is 1 for exactly one cycle after that edge, with rsp_rdata holding the byte.
- R7: mem_addr changes no more often than once every 70 ns. Every access lasts at least the read or write cycle time.
- R8: Whenever the block is idle, both selects are inactive, both strobes are high and the data driver is off.
- R9: After a read, mem_dq_oe stays 0 for at least 25 ns after mem_oe_n rises. With defaults this is two cycles, and the next request is taken only after them.
- R10: Each interval is ceil(ns/clk), with a minimum of one cycle. With defaults, req_ready is low for 5 cycles after a write is taken and for 6 cycles after a read is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 18 | Memory address pins |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_cs | output | 1 | Memory select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_in | input | 8 | Data from memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The bench contains a memory model that measures every strobe interval in nanoseconds. A controller that shortened the write pulse, or dropped the select early, would be caught as soon as mem_we_n rises. The model also flags any cycle in which the bus is driven while the memory's outputs are on, or still releasing. A design that skipped or shortened the post-read release would fail on the write that follows a read. Directed read-after-write and write-after-read pairs are mixed with random traffic over a small address pool at both address ends. These catch sampling on the wrong edge, a lost or doubled rsp_valid, and an address that follows req_addr while the block is busy.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  // one-hot so each state is a single flop
  typedef enum logic [5:0] {
    ST_IDLE = 6'b000001,
    ST_WSU  = 6'b000010,
    ST_WPL  = 6'b000100,
    ST_WHD  = 6'b001000,
    ST_RACC = 6'b010000,
    ST_TURN = 6'b100000
  } state_e;

  // nanoseconds to cycles, rounded up, at least one
  function automatic int unsigned ns2cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // subtraction clamped at zero
  function automatic int unsigned usub(input int unsigned a, input int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R10: a loaded interval starts from the requested count
  p_timer_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned N_WSU = 1,
  parameter int unsigned N_WPL = 3,
  parameter int unsigned N_WHD = 1,
  parameter int unsigned N_RD  = 4,
  parameter int unsigned N_HZ  = 2,
  parameter int          CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_done,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             sel_q,
  output logic             we_n_q,
  output logic             oe_n_q,
  output logic             dq_oe_q
);
  state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          state_d = ST_WSU;
          tmr_val = CNT_W'(N_WSU - 1);
        end else begin
          state_d = ST_RACC;
          tmr_val = CNT_W'(N_RD - 1);
        end
      end
      ST_WSU: if (tmr_done) begin
        state_d  = ST_WPL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_WPL - 1);
      end
      ST_WPL: if (tmr_done) begin
        state_d  = ST_WHD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_WHD - 1);
      end
      ST_WHD: if (tmr_done) state_d = ST_IDLE;
      ST_RACC: if (tmr_done) begin
        state_d  = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_HZ - 1);
      end
      ST_TURN: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // pins are registered from the next state so they never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= (state_d == ST_WSU) || (state_d == ST_WPL) ||
                 (state_d == ST_WHD) || (state_d == ST_RACC);
      we_n_q  <= (state_d != ST_WPL);
      oe_n_q  <= (state_d != ST_RACC);
      dq_oe_q <= (state_d == ST_WPL) || (state_d == ST_WHD);
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (state_q == ST_RACC) && tmr_done;

  // R6: the sample edge falls inside an enabled read
  p_capture_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (sel_q && !oe_n_q && we_n_q));

  // R2: a taken request makes the block busy
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: rtl/sram_ctl_data.sv
`timescale 1ns/1ps
module sram_ctl_data #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= dq_in;
    end
  end

  // R2: the address only moves when a request is taken
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(addr_q));

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int          ADDR_W    = 18,
  parameter int          DATA_W    = 8,
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned T_RC_NS   = 70,
  parameter int unsigned T_AA_NS   = 70,
  parameter int unsigned T_DOE_NS  = 35,
  parameter int unsigned T_WC_NS   = 70,
  parameter int unsigned T_PWE_NS  = 50,
  parameter int unsigned T_SCE_NS  = 60,
  parameter int unsigned T_AW_NS   = 60,
  parameter int unsigned T_SD_NS   = 30,
  parameter int unsigned T_SA_NS   = 0,
  parameter int unsigned T_HD_NS   = 0,
  parameter int unsigned T_HZOE_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int unsigned N_WSU = ns2cyc(T_SA_NS, CLK_NS);
  localparam int unsigned N_WPL = umax(umax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SD_NS, CLK_NS)),
                                       umax(usub(ns2cyc(T_SCE_NS, CLK_NS), N_WSU),
                                            usub(ns2cyc(T_AW_NS, CLK_NS), N_WSU)));
  localparam int unsigned N_WHD = umax(ns2cyc(T_HD_NS, CLK_NS),
                                       usub(ns2cyc(T_WC_NS, CLK_NS), N_WSU + N_WPL));
  localparam int unsigned N_RD  = umax(umax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_DOE_NS, CLK_NS)),
                                       ns2cyc(T_RC_NS, CLK_NS));
  localparam int unsigned N_HZ  = ns2cyc(T_HZOE_NS, CLK_NS);
  localparam int unsigned N_MAX = umax(umax(umax(N_WSU, N_WPL), umax(N_WHD, N_RD)), N_HZ);
  localparam int          CNT_W = (N_MAX > 1) ? $clog2(N_MAX) : 1;

  logic             accept, capture, tmr_load, tmr_done, sel_q;
  logic [CNT_W-1:0] tmr_val;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sram_ctl_fsm #(
    .N_WSU(N_WSU), .N_WPL(N_WPL), .N_WHD(N_WHD), .N_RD(N_RD), .N_HZ(N_HZ), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .tmr_done(tmr_done), .req_ready(req_ready), .accept(accept), .capture(capture),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .sel_q(sel_q), .we_n_q(mem_we_n),
    .oe_n_q(mem_oe_n), .dq_oe_q(mem_dq_oe)
  );

  sram_ctl_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(mem_dq_in),
    .addr_q(mem_addr), .wdata_q(mem_dq_out), .rdata_q(rsp_rdata), .rvalid_q(rsp_valid)
  );

  assign mem_cs   = sel_q;
  assign mem_cs_n = ~sel_q;

  // R4: never drive while the memory may be driving
  p_drive_oe_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R5: the write ends with data still on the bus
  p_write_end_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

  // R6: the two strobes are exclusive
  p_we_oe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R6: one pulse per read
  p_rvalid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: strobes only while selected
  p_strobe_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> (!mem_cs_n && mem_cs));

  // R8: idle means standby
  p_idle_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R9: the bus stays released in the cycle after a read ends
  p_turn_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> !mem_dq_oe);

endmodule

// File: tb/sram_ctl_bench.sv
`timescale 1ns/1ps
module sram_ctl_bench;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctl u_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  int errors = 0;
  int checks = 0;
  int contention = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // expected cycle counts, found by search rather than by formula
  function automatic int cyc(input int ns);
    int n = 1;
    while (n * CLK_NS < ns) n++;
    return n;
  endfunction
  function automatic int exp_pulse();
    int n = 1;
    while ((n * CLK_NS < 50) || (n * CLK_NS < 30) || ((n + cyc(0)) * CLK_NS < 60)) n++;
    return n;
  endfunction
  function automatic int exp_wbusy();
    int n = cyc(0) + exp_pulse() + cyc(0);
    while (n * CLK_NS < 70) n++;
    return n;
  endfunction
  function automatic int exp_rd();
    int n = 1;
    while ((n * CLK_NS < 70) || (n * CLK_NS < 35)) n++;
    return n;
  endfunction

  // behavioural memory and scoreboard
  logic [7:0] mem_m [int];
  logic [7:0] sb    [int];
  function automatic logic [7:0] mem_get(input int a);
    return mem_m.exists(a) ? mem_m[a] : 8'h00;
  endfunction
  function automatic logic [7:0] sb_get(input int a);
    return sb.exists(a) ? sb[a] : 8'h00;
  endfunction

  wire sel_on    = !mem_cs_n && mem_cs;
  wire model_drv = sel_on && !mem_oe_n && mem_we_n;
  assign mem_dq_in = model_drv ? mem_get(int'(mem_addr)) : 8'h00;

  real t_addr = -1.0e6, t_sel = -1.0e6, t_wef = -1.0e6, t_oef = -1.0e6;
  real t_oer = -1.0e6, t_data = -1.0e6;

  always @(mem_addr) begin
    if (rst_n === 1'b1)
      chk(($realtime - t_addr) >= 70.0, "R7", "address change spacing ns",
          longint'($realtime - t_addr), 70);
    t_addr = $realtime;
  end
  always @(posedge sel_on)    t_sel  = $realtime;
  always @(negedge mem_we_n)  t_wef  = $realtime;
  always @(negedge mem_oe_n)  t_oef  = $realtime;
  always @(posedge mem_oe_n)  t_oer  = $realtime;
  always @(mem_dq_out)        t_data = $realtime;

  always @(posedge mem_we_n) begin
    if (rst_n === 1'b1 && sel_on) begin
      chk(($realtime - t_wef) >= 50.0, "R3", "write strobe width ns", longint'($realtime - t_wef), 50);
      chk(($realtime - t_sel) >= 60.0, "R3", "select to write end ns", longint'($realtime - t_sel), 60);
      chk(($realtime - t_addr) >= 60.0, "R3", "address to write end ns", longint'($realtime - t_addr), 60);
      chk(($realtime - t_data) >= 30.0, "R5", "data setup ns", longint'($realtime - t_data), 30);
      chk(mem_dq_oe === 1'b1, "R5", "data driven at write end", longint'(mem_dq_oe), 1);
      mem_m[int'(mem_addr)] = mem_dq_out;
    end
  end

  always @(posedge rsp_valid) begin
    if (rst_n === 1'b1) begin
      chk(($realtime - t_oef) >= 35.0, "R6", "output enable to sample ns", longint'($realtime - t_oef), 35);
      chk(($realtime - t_addr) >= 70.0, "R6", "address to sample ns", longint'($realtime - t_addr), 70);
    end
  end

  always @(posedge mem_dq_oe) begin
    if (rst_n === 1'b1)
      chk(($realtime - t_oer) >= 25.0, "R9", "release before drive ns", longint'($realtime - t_oer), 25);
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && mem_dq_oe && (model_drv || ($realtime - t_oer) < 25.0))
      contention++;
  end

  bit prev_rd = 1'b0;

  task automatic do_op(input bit wr, input logic [17:0] a, input logic [7:0] d);
    int busy = 0, we_cyc = 0, rv_cnt = 0, rv_idx = -1, addr_bad = 0, cont0;
    logic [7:0] rv_data = 8'h00;
    @(negedge clk);
    chk(req_ready && mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R8", "idle standby pins", longint'({req_ready, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe}),
        longint'(6'b110110));
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = 18'($urandom); req_wdata = 8'($urandom);
    cont0 = contention;
    while (!req_ready && busy < 50) begin
      if (rsp_valid) begin rv_cnt++; rv_idx = busy; rv_data = rsp_rdata; end
      if (!mem_we_n) we_cyc++;
      if (mem_addr !== a) addr_bad++;
      busy++;
      @(negedge clk);
    end
    chk(addr_bad == 0, "R2", "address held while busy", addr_bad, 0);
    if (wr) begin
      chk(busy == exp_wbusy(), "R10", "write busy cycles", busy, exp_wbusy());
      chk(we_cyc == exp_pulse(), "R3", "write strobe cycles", we_cyc, exp_pulse());
      chk(contention == cont0, prev_rd ? "R9" : "R4", "bus contention count", contention - cont0, 0);
      sb[int'(a)] = d;
    end else begin
      chk(busy == exp_rd() + cyc(25), "R10", "read busy cycles", busy, exp_rd() + cyc(25));
      chk(rv_cnt == 1, "R6", "read valid pulses", rv_cnt, 1);
      chk(rv_idx == exp_rd(), "R6", "read valid cycle", rv_idx, exp_rd());
      chk(rv_data == sb_get(int'(a)), "R6", "read data", rv_data, sb_get(int'(a)));
      chk(contention == cont0, "R4", "bus contention count", contention - cont0, 0);
    end
    prev_rd = !wr;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1", "pins in reset", longint'({req_ready, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}),
        longint'(7'b1101100));
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1", "pins after reset", longint'({req_ready, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}),
        longint'(7'b1101100));
    // directed corners
    do_op(1'b1, 18'h00000, 8'h5A);
    do_op(1'b1, 18'h3FFFF, 8'hC3);
    do_op(1'b0, 18'h3FFFF, 8'h00);
    do_op(1'b0, 18'h00000, 8'h00);
    do_op(1'b0, 18'h12345, 8'h00);
    do_op(1'b1, 18'h00100, 8'hFF);
    do_op(1'b0, 18'h00100, 8'h00);
    do_op(1'b1, 18'h00100, 8'h00);
    do_op(1'b0, 18'h00100, 8'h00);
    // random traffic over a small pool at both address ends
    for (int i = 0; i < 150; i++) begin
      do_op(1'($urandom), 18'($urandom) & 18'h3000F, 8'($urandom));
    end
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule